// File: doc/BRIEF.md
# Page Program Staging Buffer

This block sits behind the serial command decoder of a flash device and takes over once the decoder has accepted a page-program opcode and its 24-bit address. It latches the page number and the starting byte offset. It then writes each incoming data byte into a one-page staging memory. The offset advances and wraps inside the page, and a per-offset valid mask records which locations were written.

When chip-select is released, the block decides whether the transfer was well formed. A transfer is well formed when it ended on a byte boundary, carried at least one byte and the write-enable flag was set. If so, the block issues a one-cycle program request. The request carries the page number, the byte count and the mask, and the block then stays busy for a self-timed period. That period has a fixed overhead plus a per-byte term. At the end of the busy period the block emits a pulse that clears the write-enable flag. A malformed transfer is dropped silently, and the write-enable flag is left as it was. The staged bytes can be read back through a combinational read port.

Top module: `pp_top`

## Requirements
- R1: A `phase_start` pulse while not busy latches the page number from `start_addr[19:8]` and the starting offset from `start_addr[7:0]`, clears the valid mask and the byte count, and opens collection. The page is reported on `prog_page`.
- R2: Each `byte_stb` accepted while collecting and `cs_n` is low stores `byte_data` at the current offset and sets that offset's bit in `prog_mask`. The offset then advances by one and wraps from 255 to 0 within the same page.
- R3: When more than 256 bytes are loaded, the staging memory holds only the last 256 loaded, and `prog_count` saturates at 256. Otherwise `prog_count` equals the number of bytes loaded.
- R4: A rising edge of `cs_n` during collection produces a single-cycle `prog_start` on the following cycle. This happens only if `bit_cnt` is 0 (the transfer ended on a byte boundary), at least one byte was loaded and `wr_enabled` is 1.
- R5: If `bit_cnt` is not 0 at the `cs_n` rise, the command is dropped. No `prog_start`, no `busy` and no `wen_clr` follow, and collection closes.
- R6: A command with zero data bytes, or one that ends while `wr_enabled` is 0, is dropped in the same way.
- R7: `busy` rises together with `prog_start` and stays high for exactly `OVH_CYC + n*CYC_PER_BYTE` cycles, where n is `prog_count`.
- R8: `wen_clr` is a one-cycle pulse in the cycle right after `busy` falls, and is never asserted otherwise.
- R9: While `busy` is high, `phase_start` and `byte_stb` have no effect. The staging memory is unchanged, and a later `cs_n` rise starts nothing.
- R10: After reset, `busy`, `prog_start` and `wen_clr` are 0, `prog_mask` is all zeros and collection is closed.
- R11: `rd_data` shows the staged byte at offset `rd_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, low while the command is in progress |
| phase_start | input | 1 | Opcode and address accepted; latch `start_addr` |
| start_addr | input | 20 | Program address: page in [19:8], offset in [7:0] |
| byte_stb | input | 1 | A complete data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte |
| bit_cnt | input | 3 | Bits of the current partial byte received; 0 on a byte boundary |
| wr_enabled | input | 1 | Current write-enable flag |
| rd_idx | input | 8 | Read-back offset |
| rd_data | output | 8 | Staged byte at `rd_idx` |
| prog_start | output | 1 | One-cycle program request |
| prog_page | output | 12 | Page number of the request |
| prog_count | output | 9 | Bytes to program, 1 to 256 |
| prog_mask | output | 256 | Offsets that hold staged data |
| busy | output | 1 | Self-timed program period in progress |
| wen_clr | output | 1 | Pulse that clears the write-enable flag |

## Verification
The main function is tried with four transfer shapes:
- A short run from a mid-page offset tests basic placement and the busy length scaling with n.
- A run that starts two bytes below the page end separates a correct in-page wrap from a carry into the page number.
- A 300-byte run shows whether the oldest bytes are overwritten and whether the count saturates.
- Releases with a partial byte, with no bytes, or with writes disabled tell a well-formed command apart from each of the three dropping reasons.

A last run issues a new address and new bytes during the busy period. It shows that the staged page is frozen until the period ends.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [1:0] {
        V_NONE = 2'd0,
        V_GO   = 2'd1,
        V_DROP = 2'd2
    } verdict_e;

    function automatic int unsigned prog_cycles(input int unsigned n,
                                                input int unsigned ovh,
                                                input int unsigned cpb);
        return ovh + n * cpb;
    endfunction

endpackage

// File: rtl/pp_stage.sv
module pp_stage #(
    parameter int ADDR_W  = 20,
    parameter int PAGE_AW = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic                        close,
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           start_addr,
    input  logic [7:0]                  byte_data,
    input  logic [PAGE_AW-1:0]          rd_idx,
    output logic [7:0]                  rd_data,
    output logic                        collecting,
    output logic [ADDR_W-PAGE_AW-1:0]   page,
    output logic [PAGE_AW:0]            count,
    output logic [(1<<PAGE_AW)-1:0]     mask
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int CW         = PAGE_AW + 1;

    logic [7:0]         mem [PAGE_BYTES];
    logic [PAGE_AW-1:0] offset;
    logic               store;

    assign store = !load && !close && wr && collecting;

    always_ff @(posedge clk) begin
        if (rst) begin
            collecting <= 1'b0;
            page       <= '0;
            offset     <= '0;
            count      <= '0;
            mask       <= '0;
        end else if (load) begin
            collecting <= 1'b1;
            page       <= start_addr[ADDR_W-1:PAGE_AW];
            offset     <= start_addr[PAGE_AW-1:0];
            count      <= '0;
            mask       <= '0;
        end else if (close) begin
            collecting <= 1'b0;
        end else if (store) begin
            mask[offset] <= 1'b1;
            offset       <= offset + 1'b1;
            if (count != CW'(PAGE_BYTES))
                count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && store)
            mem[offset] <= byte_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/pp_validate.sv
module pp_validate #(
    parameter int PAGE_AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic [2:0]       bit_cnt,
    input  logic             collecting,
    input  logic [PAGE_AW:0] count,
    input  logic             wr_enabled,
    input  logic             busy,
    output logic             cs_rise,
    output logic             go
);
    import pp_pkg::*;

    logic     cs_q;
    verdict_e verdict;

    always_ff @(posedge clk) begin
        if (rst) cs_q <= 1'b1;
        else     cs_q <= cs_n;
    end

    assign cs_rise = cs_n && !cs_q;

    always_comb begin
        verdict = V_NONE;
        if (cs_rise && collecting) begin
            if (bit_cnt == 3'd0 && count != '0 && wr_enabled)
                verdict = V_GO;
            else
                verdict = V_DROP;
        end
    end

    assign go = (verdict == V_GO) && !busy;

endmodule

// File: rtl/pp_timer.sv
module pp_timer #(
    parameter int PAGE_AW      = 8,
    parameter int OVH_CYC      = 12,
    parameter int CYC_PER_BYTE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [PAGE_AW:0] count,
    output logic             busy,
    output logic             prog_start,
    output logic             wen_clr
);
    import pp_pkg::*;

    localparam int MAX_CYC = OVH_CYC + (1 << PAGE_AW) * CYC_PER_BYTE;
    localparam int TW      = $clog2(MAX_CYC + 1);

    logic [TW-1:0] tmr;
    int unsigned   dur;

    assign dur = prog_cycles(32'(count), OVH_CYC, CYC_PER_BYTE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            prog_start <= 1'b0;
            wen_clr    <= 1'b0;
            tmr        <= '0;
        end else begin
            prog_start <= go && !busy;
            wen_clr    <= 1'b0;
            if (busy) begin
                if (tmr == '0) begin
                    busy    <= 1'b0;
                    wen_clr <= 1'b1;
                end else begin
                    tmr <= tmr - 1'b1;
                end
            end else if (go) begin
                busy <= 1'b1;
                tmr  <= TW'(dur - 1);
            end
        end
    end

endmodule

// File: rtl/pp_top.sv
module pp_top #(
    parameter int ADDR_W       = 20,
    parameter int PAGE_AW      = 8,
    parameter int OVH_CYC      = 12,
    parameter int CYC_PER_BYTE = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs_n,
    input  logic                      phase_start,
    input  logic [ADDR_W-1:0]         start_addr,
    input  logic                      byte_stb,
    input  logic [7:0]                byte_data,
    input  logic [2:0]                bit_cnt,
    input  logic                      wr_enabled,
    input  logic [PAGE_AW-1:0]        rd_idx,
    output logic [7:0]                rd_data,
    output logic                      prog_start,
    output logic [ADDR_W-PAGE_AW-1:0] prog_page,
    output logic [PAGE_AW:0]          prog_count,
    output logic [(1<<PAGE_AW)-1:0]   prog_mask,
    output logic                      busy,
    output logic                      wen_clr
);
    logic collecting;
    logic cs_rise;
    logic go;
    logic load;
    logic wr;

    assign load = phase_start && !busy;
    assign wr   = byte_stb && !cs_n && !busy;

    pp_stage #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .close      (cs_rise),
        .wr         (wr),
        .start_addr (start_addr),
        .byte_data  (byte_data),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .collecting (collecting),
        .page       (prog_page),
        .count      (prog_count),
        .mask       (prog_mask)
    );

    pp_validate #(.PAGE_AW(PAGE_AW)) u_val (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .bit_cnt    (bit_cnt),
        .collecting (collecting),
        .count      (prog_count),
        .wr_enabled (wr_enabled),
        .busy       (busy),
        .cs_rise    (cs_rise),
        .go         (go)
    );

    pp_timer #(.PAGE_AW(PAGE_AW), .OVH_CYC(OVH_CYC), .CYC_PER_BYTE(CYC_PER_BYTE)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .count      (prog_count),
        .busy       (busy),
        .prog_start (prog_start),
        .wen_clr    (wen_clr)
    );

endmodule

// File: rtl/pp_top_chk.sv
module pp_top_chk #(
    parameter int PAGE_AW = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cs_n,
    input logic [2:0]              bit_cnt,
    input logic                    prog_start,
    input logic [PAGE_AW:0]        prog_count,
    input logic [(1<<PAGE_AW)-1:0] prog_mask,
    input logic                    busy,
    input logic                    wen_clr
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;

    p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> !prog_start);

    p_start_boundary_r5: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> ($past(bit_cnt) == 3'd0 && $past(cs_n)));

    p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> busy);

    p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> (prog_count != '0 && 32'(prog_count) <= PAGE_BYTES));

    p_mask_match_r2: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> ($countones(prog_mask) == 32'(prog_count)));

    p_clr_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
        wen_clr |-> ($past(busy) && !busy));

    p_busy_fall_clr_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> wen_clr);

    p_busy_entry_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> prog_start);

endmodule

bind pp_top pp_top_chk #(.PAGE_AW(PAGE_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .bit_cnt    (bit_cnt),
    .prog_start (prog_start),
    .prog_count (prog_count),
    .prog_mask  (prog_mask),
    .busy       (busy),
    .wen_clr    (wen_clr)
);

// File: tb/pp_top_test.sv
`timescale 1ns/1ps
module pp_top_test;
    localparam int OVH = 12;
    localparam int CPB = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         phase_start = 1'b0;
    logic [19:0]  start_addr = '0;
    logic         byte_stb = 1'b0;
    logic [7:0]   byte_data = '0;
    logic [2:0]   bit_cnt = '0;
    logic         wr_enabled = 1'b1;
    logic [7:0]   rd_idx = '0;
    logic [7:0]   rd_data;
    logic         prog_start;
    logic [11:0]  prog_page;
    logic [8:0]   prog_count;
    logic [255:0] prog_mask;
    logic         busy;
    logic         wen_clr;

    always #5 clk = ~clk;

    pp_top #(.OVH_CYC(OVH), .CYC_PER_BYTE(CPB)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .phase_start(phase_start),
        .start_addr(start_addr), .byte_stb(byte_stb), .byte_data(byte_data),
        .bit_cnt(bit_cnt), .wr_enabled(wr_enabled), .rd_idx(rd_idx),
        .rd_data(rd_data), .prog_start(prog_start), .prog_page(prog_page),
        .prog_count(prog_count), .prog_mask(prog_mask), .busy(busy),
        .wen_clr(wen_clr)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit        m_coll, m_busy, m_ps, m_wc, m_csq;
    int        m_page, m_off, m_cnt, m_tmr;
    bit [7:0]  m_mem [256];
    bit [255:0] m_mask;

    always @(posedge clk) begin
        bit rise, go, b0;
        if (rst) begin
            m_coll = 0; m_busy = 0; m_ps = 0; m_wc = 0; m_csq = 1;
            m_page = 0; m_off = 0; m_cnt = 0; m_tmr = 0; m_mask = '0;
        end else begin
            b0   = m_busy;
            rise = cs_n && !m_csq;
            m_csq = cs_n;
            go   = rise && m_coll && bit_cnt == 0 && m_cnt > 0 && wr_enabled && !b0;
            m_ps = go;
            m_wc = 0;
            if (b0) begin
                if (m_tmr == 0) begin m_busy = 0; m_wc = 1; end
                else m_tmr--;
            end else if (go) begin
                m_busy = 1;
                m_tmr  = OVH + m_cnt * CPB - 1;
            end
            if (phase_start && !b0) begin
                m_coll = 1; m_page = int'(start_addr >> 8); m_off = int'(start_addr & 20'hFF);
                m_cnt = 0; m_mask = '0;
            end else if (rise) begin
                m_coll = 0;
            end else if (byte_stb && !cs_n && !b0 && m_coll) begin
                m_mem[m_off] = byte_data;
                m_mask[m_off] = 1'b1;
                m_off = (m_off + 1) % 256;
                if (m_cnt < 256) m_cnt++;
            end
        end
    end

    bit saw_ps, saw_wc;
    always @(negedge clk) begin
        if (!rst) begin
            chk(busy == m_busy, "R7 busy", 256'(busy), 256'(m_busy));
            chk(prog_start == m_ps, "R4 prog_start", 256'(prog_start), 256'(m_ps));
            chk(wen_clr == m_wc, "R8 wen_clr", 256'(wen_clr), 256'(m_wc));
            if (m_ps) begin
                chk(prog_page == 12'(m_page), "R1 page", 256'(prog_page), 256'(m_page));
                chk(prog_count == 9'(m_cnt), "R3 count", 256'(prog_count), 256'(m_cnt));
                chk(prog_mask == m_mask, "R2 mask", prog_mask, m_mask);
            end
            if (prog_start) saw_ps = 1;
            if (wen_clr)    saw_wc = 1;
        end
    end

    task automatic begin_cmd(input logic [19:0] a);
        @(negedge clk);
        cs_n = 0; phase_start = 1; start_addr = a;
        @(negedge clk);
        phase_start = 0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        byte_data = d; byte_stb = 1;
        @(negedge clk);
        byte_stb = 0;
    endtask

    task automatic end_cmd(input logic [2:0] bc);
        bit_cnt = bc;
        cs_n = 1;
        @(negedge clk);
        @(negedge clk);
        bit_cnt = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_drop(input string tag);
        saw_ps = 0; saw_wc = 0;
        repeat (40) @(negedge clk);
        chk(!saw_ps, tag, 256'(saw_ps), 256'(0));
        chk(!saw_wc, tag, 256'(saw_wc), 256'(0));
        chk(!busy, tag, 256'(busy), 256'(0));
    endtask

    task automatic rd_check(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        rd_idx = idx;
        #1;
        chk(rd_data == exp, tag, 256'(rd_data), 256'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] snap [256];
        int len;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk(busy == 0, "R10 busy", 256'(busy), 256'(0));
        chk(prog_start == 0, "R10 prog_start", 256'(prog_start), 256'(0));
        chk(wen_clr == 0, "R10 wen_clr", 256'(wen_clr), 256'(0));
        chk(prog_mask == '0, "R10 mask", prog_mask, 256'(0));

        // short run from mid-page offset: R1 R4 R7 R11
        begin_cmd(20'h12340);
        for (int i = 0; i < 4; i++) send_byte(8'hC0 + 8'(i));
        bit_cnt = 0; cs_n = 1;
        @(negedge clk);
        chk(prog_start == 1, "R4 start after rise", 256'(prog_start), 256'(1));
        chk(prog_page == 12'h123, "R1 page latched", 256'(prog_page), 256'h123);
        chk(prog_count == 9'd4, "R3 count 4", 256'(prog_count), 256'd4);
        len = 0;
        while (busy) begin len++; @(negedge clk); end
        chk(len == OVH + 4 * CPB, "R7 busy length", 256'(len), 256'(OVH + 4 * CPB));
        chk(wen_clr == 1, "R8 clr after busy", 256'(wen_clr), 256'(1));
        for (int i = 0; i < 4; i++)
            rd_check(8'h40 + 8'(i), 8'hC0 + 8'(i), "R11 readback");
        wait_idle();

        // wrap inside page: R2
        begin_cmd(20'hABCFE);
        for (int i = 0; i < 5; i++) send_byte(8'h10 + 8'(i));
        end_cmd(3'd0);
        chk(prog_mask[8'hFE] && prog_mask[8'h02] && !prog_mask[8'h03], "R2 wrap mask",
            prog_mask, 256'(0));
        chk(prog_page == 12'hABC, "R2 page kept on wrap", 256'(prog_page), 256'hABC);
        wait_idle();
        rd_check(8'hFE, 8'h10, "R2 wrap fe");
        rd_check(8'hFF, 8'h11, "R2 wrap ff");
        rd_check(8'h00, 8'h12, "R2 wrap 00");
        rd_check(8'h02, 8'h14, "R2 wrap 02");

        // overrun: R3
        begin_cmd(20'h00510);
        for (int i = 0; i < 300; i++) send_byte(8'(i) ^ 8'hA5);
        end_cmd(3'd0);
        chk(prog_count == 9'd256, "R3 saturate", 256'(prog_count), 256'd256);
        wait_idle();
        for (int o = 0; o < 256; o++) begin
            int k;
            k = (o - 16 + 256) % 256;
            if (k + 256 < 300) k = k + 256;
            rd_check(8'(o), 8'(k) ^ 8'hA5, "R3 last 256 kept");
        end

        // partial byte at release: R5
        begin_cmd(20'h00700);
        send_byte(8'h77); send_byte(8'h78);
        bit_cnt = 3'd5; cs_n = 1;
        @(negedge clk);
        bit_cnt = 0;
        expect_drop("R5 partial byte dropped");

        // zero bytes: R6
        begin_cmd(20'h00800);
        end_cmd(3'd0);
        expect_drop("R6 zero bytes dropped");

        // writes disabled: R6
        wr_enabled = 0;
        begin_cmd(20'h00900);
        send_byte(8'h99);
        end_cmd(3'd0);
        expect_drop("R6 write disabled dropped");
        wr_enabled = 1;

        // activity during busy ignored: R9
        begin_cmd(20'h00A00);
        for (int i = 0; i < 8; i++) send_byte(8'h3C + 8'(i));
        end_cmd(3'd0);
        for (int o = 0; o < 256; o++) begin
            rd_idx = 8'(o); #1; snap[o] = rd_data;
        end
        chk(busy == 1, "R9 busy entered", 256'(busy), 256'(1));
        begin_cmd(20'h00B20);
        for (int i = 0; i < 6; i++) send_byte(8'hEE);
        end_cmd(3'd0);
        wait_idle();
        for (int o = 0; o < 256; o++) rd_check(8'(o), snap[o], "R9 memory unchanged");
        chk(prog_page == 12'h00A, "R9 page unchanged", 256'(prog_page), 256'h00A);
        cs_n = 0;
        @(negedge clk);
        cs_n = 1;
        expect_drop("R9 no late start");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule